// File: doc/BRIEF.md
# Block-Ack Transmit Window Tracker

This block keeps transmit state for one queue of frames held in a circular descriptor ring of `2**RING_W` entries. Each frame's ring index is its start sequence number taken modulo the ring size. A producer appends frames by advancing the write pointer. The tracker offers one frame at a time to a transmitter. It also takes in acknowledgement results and retires finished frames by advancing the read pointer.

The block runs in one of two modes. In aggregation mode it covers a sliding window of up to `WIN` frames that starts at the read pointer, and it keeps a sent bit and an acknowledged bit for each frame. A block-ack report gives a starting sequence number and a `WIN`-bit bitmap. A report can acknowledge frames in any order. Sent frames that the report leaves unacknowledged become eligible for transmission again. The read pointer moves past the acknowledged frames at the head of the window, and at most `FRAME_LIMIT` frames are offered between two reports.

In FIFO mode the read pointer names the next frame to send, and only that frame is in flight. It is resent until it is acknowledged. After `RETRY_LIMIT` failed attempts it is dropped and a failure pulse is raised.

Top module: `txw_window_tracker`

## Requirements
- R1: After synchronous reset both pointers are 0, `empty`=1, `full`=0, `tx_valid`=0, `win_space`=1 and `fail_pulse`=0.
- R2: `push` advances `wr_ptr` by one, modulo the ring size, unless the queue is full. `full`=1 when `wr_ptr`+1 equals `rd_ptr`, and a push while full leaves `wr_ptr` unchanged. `empty`=1 when the two pointers are equal.
- R3: In aggregation mode `tx_valid`/`tx_idx` offer the unsent, unacknowledged frame with the lowest offset among the first min(count, `WIN`) frames from `rd_ptr`. `tx_take` while `tx_valid` marks that frame as sent.
- R4: In aggregation mode, once `FRAME_LIMIT` frames have been taken since the last block-ack report, `tx_valid` goes low. The next report restarts the count.
- R5: Bit i of `ba_map` refers to the frame with ring index (`ba_ssn`+i) modulo the ring size. Within the window, a set bit marks a sent frame as acknowledged and a clear bit makes a sent, unacknowledged frame eligible again. Frames that are unsent, already acknowledged or outside the window are not affected.
- R6: In aggregation mode `rd_ptr` advances by one per clock while the head frame is acknowledged. It starts on the clock after the acknowledgement is recorded and stops at the first unacknowledged frame.
- R7: `win_space`=1 when the queued count (`wr_ptr`-`rd_ptr`) is below `WIN` in aggregation mode, or is zero in FIFO mode.
- R8: In FIFO mode `tx_idx` equals `rd_ptr` and `tx_valid`=1 only when the queue is not empty and no frame is in flight. A take puts the frame in flight and lowers `tx_valid` until a result arrives.
- R9: In FIFO mode `res_valid` with `res_ok`=1 retires the in-flight frame. With `res_ok`=0 the frame is offered again, and on the `RETRY_LIMIT`-th failure it is retired anyway and `fail_pulse` is 1 for one cycle.
- R10: Block-ack reports have no effect in FIFO mode, and `res_valid` has no effect in aggregation mode.
- R11: Offered indices and the pointers wrap modulo the ring size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_agg | input | 1 | 1 = aggregation window mode, 0 = FIFO retry mode (static after reset) |
| push | input | 1 | Append one frame at the write pointer |
| wr_ptr | output | RING_W | Write pointer |
| rd_ptr | output | RING_W | Read pointer |
| full | output | 1 | Ring full |
| empty | output | 1 | Ring empty |
| tx_valid | output | 1 | A frame is offered for transmission |
| tx_idx | output | RING_W | Ring index of the offered frame |
| tx_take | input | 1 | Transmitter takes the offered frame |
| ba_valid | input | 1 | Block-ack report strobe |
| ba_ssn | input | RING_W | Sequence number of bitmap bit 0 |
| ba_map | input | WIN | Acknowledgement bitmap |
| res_valid | input | 1 | FIFO-mode result strobe |
| res_ok | input | 1 | FIFO-mode result: 1 acknowledged, 0 failed |
| win_space | output | 1 | Room for another frame under the window limit |
| fail_pulse | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The bench builds the tracker with `RING_W`=5, `WIN`=8, `FRAME_LIMIT`=3 and `RETRY_LIMIT`=3. With a 32-entry ring, filling the ring and wrapping both pointers take only a few dozen frames. An eight-frame window makes the window-space threshold and the out-of-window filtering of reports easy to reach. A limit of three taken frames lets the bench sweep every acknowledgement pattern over the first three frames, and for each pattern it computes the expected head run and the next offered frame from the pattern's bits. Three attempts per frame bring the drop and failure pulse within a few cycles.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic {
    TXW_FIFO = 1'b0,
    TXW_AGG  = 1'b1
  } txw_mode_e;
endpackage

// File: rtl/txw_ring_ptrs.sv
module txw_ring_ptrs #(
  parameter int RING_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              adv,
  output logic [RING_W-1:0] wr_q,
  output logic [RING_W-1:0] rd_q,
  output logic [RING_W-1:0] wr_n,
  output logic [RING_W-1:0] rd_n,
  output logic              full_q,
  output logic              empty_q
);
  localparam logic [RING_W-1:0] ONE = RING_W'(1);

  logic at_full;
  assign at_full = (wr_q + ONE) == rd_q;

  always_comb begin
    wr_n = (push && !at_full) ? wr_q + ONE : wr_q;
    rd_n = adv ? rd_q + ONE : rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      full_q  <= (wr_n + ONE) == rd_n;
      empty_q <= wr_n == rd_n;
    end
  end
endmodule

// File: rtl/txw_agg_window.sv
module txw_agg_window #(
  parameter int RING_W      = 8,
  parameter int WIN         = 64,
  parameter int FRAME_LIMIT = 10,
  parameter int SLOT_W      = $clog2(WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [RING_W-1:0] rd_q,
  input  logic [RING_W-1:0] wr_q,
  input  logic [RING_W-1:0] rd_n,
  input  logic [RING_W-1:0] wr_n,
  input  logic              take,
  input  logic [SLOT_W-1:0] take_slot,
  input  logic              ba_valid,
  input  logic [RING_W-1:0] ba_ssn,
  input  logic [WIN-1:0]    ba_map,
  output logic              head_adv,
  output logic              offer,
  output logic [RING_W-1:0] offer_idx
);
  localparam int CH_W = $clog2(FRAME_LIMIT + 1);

  logic [WIN-1:0]    sent_q, acked_q, sent_n, acked_n;
  logic [CH_W-1:0]   chain_q, chain_n;
  logic [RING_W-1:0] cnt_c, cnt_n;
  logic [RING_W-1:0] fr, rel, fr2;
  logic [SLOT_W-1:0] slot, slot2;
  logic              found;
  int                lim_c, lim_n;

  function automatic int lim_of(input logic [RING_W-1:0] c);
    return (int'(c) >= WIN) ? WIN : int'(c);
  endfunction

  // head retirement uses registered status only
  assign head_adv = en && (wr_q != rd_q) && acked_q[rd_q[SLOT_W-1:0]];

  always_comb begin
    sent_n  = sent_q;
    acked_n = acked_q;
    chain_n = chain_q;
    cnt_c   = wr_q - rd_q;
    lim_c   = lim_of(cnt_c);
    fr      = '0;
    rel     = '0;
    slot    = '0;
    if (head_adv) begin
      sent_n[rd_q[SLOT_W-1:0]]  = 1'b0;
      acked_n[rd_q[SLOT_W-1:0]] = 1'b0;
    end
    if (en && ba_valid) begin
      chain_n = '0;
      for (int o = 0; o < WIN; o++) begin
        fr   = rd_q + o[RING_W-1:0];
        rel  = fr - ba_ssn;
        slot = fr[SLOT_W-1:0];
        if (o < lim_c && int'(rel) < WIN && sent_q[slot] && !acked_q[slot]) begin
          if (ba_map[rel[SLOT_W-1:0]]) acked_n[slot] = 1'b1;
          else                         sent_n[slot]  = 1'b0;
        end
      end
    end
    if (en && take) begin
      sent_n[take_slot] = 1'b1;
      chain_n           = chain_n + CH_W'(1);
    end
  end

  // next offer is searched on next-state so the registered offer is never stale
  always_comb begin
    cnt_n     = wr_n - rd_n;
    lim_n     = lim_of(cnt_n);
    found     = 1'b0;
    offer_idx = rd_n;
    fr2       = '0;
    slot2     = '0;
    for (int o = 0; o < WIN; o++) begin
      fr2   = rd_n + o[RING_W-1:0];
      slot2 = fr2[SLOT_W-1:0];
      if (!found && o < lim_n && !sent_n[slot2] && !acked_n[slot2]) begin
        found     = 1'b1;
        offer_idx = fr2;
      end
    end
    offer = en && found && (int'(chain_n) < FRAME_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sent_q  <= '0;
      acked_q <= '0;
      chain_q <= '0;
    end else if (en) begin
      sent_q  <= sent_n;
      acked_q <= acked_n;
      chain_q <= chain_n;
    end
  end
endmodule

// File: rtl/txw_fifo_retry.sv
module txw_fifo_retry #(
  parameter int RETRY_LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic take,
  input  logic res_valid,
  input  logic res_ok,
  output logic adv,
  output logic drop,
  output logic fly_n
);
  localparam int RT_W = $clog2(RETRY_LIMIT + 1);

  logic            fly_q;
  logic [RT_W-1:0] retry_q, retry_n;
  logic            judge, last;

  assign last  = int'(retry_q) == (RETRY_LIMIT - 1);
  assign judge = en && fly_q && res_valid;
  assign adv   = judge && (res_ok || last);
  assign drop  = judge && !res_ok && last;

  always_comb begin
    fly_n   = fly_q;
    retry_n = retry_q;
    if (en && take)   fly_n = 1'b1;
    else if (judge)   fly_n = 1'b0;
    if (adv)          retry_n = '0;
    else if (judge)   retry_n = retry_q + RT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fly_q   <= 1'b0;
      retry_q <= '0;
    end else begin
      fly_q   <= fly_n;
      retry_q <= retry_n;
    end
  end
endmodule

// File: rtl/txw_window_tracker.sv
module txw_window_tracker
  import txw_pkg::*;
#(
  parameter int RING_W      = 8,
  parameter int WIN         = 64,
  parameter int FRAME_LIMIT = 10,
  parameter int RETRY_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_agg,
  input  logic              push,
  output logic [RING_W-1:0] wr_ptr,
  output logic [RING_W-1:0] rd_ptr,
  output logic              full,
  output logic              empty,
  output logic              tx_valid,
  output logic [RING_W-1:0] tx_idx,
  input  logic              tx_take,
  input  logic              ba_valid,
  input  logic [RING_W-1:0] ba_ssn,
  input  logic [WIN-1:0]    ba_map,
  input  logic              res_valid,
  input  logic              res_ok,
  output logic              win_space,
  output logic              fail_pulse
);
  localparam int SLOT_W = $clog2(WIN);

  txw_mode_e         mode;
  logic              take, adv, agg_adv, fifo_adv, drop, fly_n;
  logic              agg_offer, fifo_offer;
  logic [RING_W-1:0] agg_idx, wr_n, rd_n, cnt_n;

  assign mode = txw_mode_e'(mode_agg);
  assign take = tx_take && tx_valid;
  assign adv  = (mode == TXW_AGG) ? agg_adv : fifo_adv;

  txw_ring_ptrs #(.RING_W(RING_W)) ptrs_i (
    .clk(clk), .rst(rst), .push(push), .adv(adv),
    .wr_q(wr_ptr), .rd_q(rd_ptr), .wr_n(wr_n), .rd_n(rd_n),
    .full_q(full), .empty_q(empty)
  );

  txw_agg_window #(.RING_W(RING_W), .WIN(WIN), .FRAME_LIMIT(FRAME_LIMIT)) agg_i (
    .clk(clk), .rst(rst), .en(mode == TXW_AGG),
    .rd_q(rd_ptr), .wr_q(wr_ptr), .rd_n(rd_n), .wr_n(wr_n),
    .take(take), .take_slot(tx_idx[SLOT_W-1:0]),
    .ba_valid(ba_valid), .ba_ssn(ba_ssn), .ba_map(ba_map),
    .head_adv(agg_adv), .offer(agg_offer), .offer_idx(agg_idx)
  );

  txw_fifo_retry #(.RETRY_LIMIT(RETRY_LIMIT)) fifo_i (
    .clk(clk), .rst(rst), .en(mode == TXW_FIFO),
    .take(take), .res_valid(res_valid), .res_ok(res_ok),
    .adv(fifo_adv), .drop(drop), .fly_n(fly_n)
  );

  assign cnt_n      = wr_n - rd_n;
  assign fifo_offer = !fly_n && (wr_n != rd_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid   <= 1'b0;
      tx_idx     <= '0;
      win_space  <= 1'b1;
      fail_pulse <= 1'b0;
    end else begin
      if (mode == TXW_AGG) begin
        tx_valid  <= agg_offer;
        tx_idx    <= agg_idx;
        win_space <= int'(cnt_n) < WIN;
      end else begin
        tx_valid  <= fifo_offer;
        tx_idx    <= rd_n;
        win_space <= cnt_n == '0;
      end
      fail_pulse <= drop;
    end
  end
endmodule

// File: rtl/txw_window_tracker_chk.sv
module txw_window_tracker_chk #(
  parameter int RING_W = 8,
  parameter int WIN    = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_agg,
  input logic              push,
  input logic [RING_W-1:0] wr_ptr,
  input logic [RING_W-1:0] rd_ptr,
  input logic              full,
  input logic              empty,
  input logic              tx_valid,
  input logic [RING_W-1:0] tx_idx,
  input logic              tx_take,
  input logic              fail_pulse
);
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R2
  AST_FULL_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
    full && push |=> wr_ptr == $past(wr_ptr)); // R2
  AST_RD_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    rd_ptr != $past(rd_ptr) |-> rd_ptr == $past(rd_ptr) + RING_W'(1)); // R6
  AST_OFFER_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !empty); // R3
  AST_AGG_SPAN: assert property (@(posedge clk) disable iff (rst)
    tx_valid && mode_agg |-> int'(tx_idx - rd_ptr) < WIN); // R3
  AST_FIFO_HEAD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !mode_agg |-> tx_idx == rd_ptr); // R8
  AST_FIFO_ONE_FLY: assert property (@(posedge clk) disable iff (rst)
    !mode_agg && tx_take && tx_valid |=> !tx_valid); // R8
  AST_FAIL_ONE: assert property (@(posedge clk) disable iff (rst)
    fail_pulse |=> !fail_pulse); // R9
  AST_FAIL_FIFO: assert property (@(posedge clk) disable iff (rst)
    fail_pulse |-> !mode_agg); // R10
endmodule

bind txw_window_tracker txw_window_tracker_chk #(.RING_W(RING_W), .WIN(WIN)) chk_i (.*);

// File: tb/txw_window_tracker_tb.sv
module txw_window_tracker_tb_top;
  localparam int RING_W = 5;
  localparam int WIN    = 8;
  localparam int FL     = 3;
  localparam int RL     = 3;
  localparam int RING   = 1 << RING_W;

  logic              clk = 1'b0;
  logic              rst, mode_agg, push, tx_take, ba_valid, res_valid, res_ok;
  logic [RING_W-1:0] ba_ssn, wr_ptr, rd_ptr, tx_idx;
  logic [WIN-1:0]    ba_map;
  logic              full, empty, tx_valid, win_space, fail_pulse;
  int                total = 0, bad = 0;
  bit                done = 0;

  always #4 clk = ~clk;

  txw_window_tracker #(.RING_W(RING_W), .WIN(WIN), .FRAME_LIMIT(FL), .RETRY_LIMIT(RL)) dut_i (
    .clk(clk), .rst(rst), .mode_agg(mode_agg), .push(push),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty),
    .tx_valid(tx_valid), .tx_idx(tx_idx), .tx_take(tx_take),
    .ba_valid(ba_valid), .ba_ssn(ba_ssn), .ba_map(ba_map),
    .res_valid(res_valid), .res_ok(res_ok),
    .win_space(win_space), .fail_pulse(fail_pulse)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1; mode_agg = m; push = 0; tx_take = 0; ba_valid = 0;
    res_valid = 0; res_ok = 0; ba_ssn = '0; ba_map = '0;
    tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic push_n(input int n);
    push = 1'b1;
    repeat (n) tick();
    push = 1'b0;
  endtask

  task automatic take1();
    tx_take = 1'b1; tick(); tx_take = 1'b0;
  endtask

  task automatic send_ba(input int ssn, input int map);
    ba_valid = 1'b1; ba_ssn = RING_W'(ssn); ba_map = WIN'(map);
    tick();
    ba_valid = 1'b0;
  endtask

  task automatic send_res(input logic ok);
    res_valid = 1'b1; res_ok = ok; tick(); res_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // ---------------- aggregation directed ----------------
    do_reset(1'b1);
    check("R1 rd_ptr", rd_ptr, 0);
    check("R1 wr_ptr", wr_ptr, 0);
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 win_space", win_space, 1);
    check("R1 fail_pulse", fail_pulse, 0);

    push_n(10);
    check("R2 wr_ptr after 10", wr_ptr, 10);
    check("R7 win_space count10", win_space, 0);
    check("R3 tx_valid", tx_valid, 1);
    check("R3 tx_idx first", tx_idx, 0);
    take1();
    check("R3 tx_idx after take", tx_idx, 1);
    take1(); take1();
    check("R4 limit reached", tx_valid, 0);

    send_ba(0, 'b101);
    check("R4 report restarts", tx_valid, 1);
    check("R5 retransmit offered", tx_idx, 1);
    check("R6 rd not yet moved", rd_ptr, 0);
    tick();
    check("R6 rd after one clock", rd_ptr, 1);
    tick(); tick();
    check("R6 rd stops at gap", rd_ptr, 1);

    take1();
    check("R3 skips acked frame", tx_idx, 3);
    send_ba(1, 'b1);
    repeat (3) tick();
    check("R6 run of two retired", rd_ptr, 3);
    check("R7 win_space count7", win_space, 1);

    send_ba(20, 'hFF);
    repeat (2) tick();
    check("R5 out-of-window rd", rd_ptr, 3);
    check("R5 out-of-window idx", tx_idx, 3);

    take1(); take1();
    check("R3 offer after two takes", tx_idx, 5);
    send_ba(3, 'b10);
    check("R5 unacked head reoffered", tx_idx, 3);
    repeat (3) tick();
    check("R6 out-of-order no advance", rd_ptr, 3);
    take1();
    check("R3 next after retake", tx_idx, 5);
    send_ba(3, 'b01);
    repeat (4) tick();
    check("R5 acked frame kept", rd_ptr, 5);
    check("R3 offer after advance", tx_idx, 5);

    // ---------------- aggregation pattern sweep ----------------
    for (int p = 0; p < 8; p++) begin
      int t, z;
      do_reset(1'b1);
      push_n(8);
      take1(); take1(); take1();
      send_ba(0, (5'b10110 << 3) | p);
      repeat (5) tick();
      t = 0;
      while (t < 3 && ((p >> t) & 1) == 1) t++;
      z = t;
      check($sformatf("R6 sweep p=%0d rd", p), rd_ptr, t);
      check($sformatf("R5 sweep p=%0d idx", p), tx_idx, z);
      check($sformatf("R7 sweep p=%0d space", p), win_space, (t > 0) ? 1 : 0);
      check($sformatf("R4 sweep p=%0d valid", p), tx_valid, 1);
    end

    // ---------------- full ring ----------------
    do_reset(1'b1);
    push_n(RING + 1);
    check("R2 wr_ptr saturates", wr_ptr, RING - 1);
    check("R2 full", full, 1);
    check("R2 not empty", empty, 0);
    send_res(1'b1);
    tick();
    check("R10 result ignored in agg", rd_ptr, 0);

    // ---------------- FIFO directed ----------------
    do_reset(1'b0);
    check("R7 fifo empty space", win_space, 1);
    push_n(2);
    check("R8 fifo offer", tx_valid, 1);
    check("R8 fifo idx", tx_idx, 0);
    check("R7 fifo busy space", win_space, 0);
    take1();
    check("R8 in flight", tx_valid, 0);
    send_ba(0, 'hFF);
    check("R10 report ignored valid", tx_valid, 0);
    check("R10 report ignored rd", rd_ptr, 0);
    send_res(1'b0);
    check("R9 retry offered", tx_valid, 1);
    check("R9 retry idx", tx_idx, 0);
    take1(); send_res(1'b0);
    check("R9 second fail no drop", fail_pulse, 0);
    take1(); send_res(1'b0);
    check("R9 drop pulse", fail_pulse, 1);
    check("R9 drop advances", rd_ptr, 1);
    check("R9 next idx", tx_idx, 1);
    tick();
    check("R9 pulse one cycle", fail_pulse, 0);
    take1(); send_res(1'b1);
    check("R9 success advances", rd_ptr, 2);
    check("R9 empty after", empty, 1);
    check("R8 no offer when empty", tx_valid, 0);

    // ---------------- FIFO wrap sweep ----------------
    for (int n = 2; n < 42; n++) begin
      push_n(1);
      check($sformatf("R11 offer n=%0d", n), tx_valid, 1);
      check($sformatf("R11 idx n=%0d", n), tx_idx, n % RING);
      take1();
      if (n % 2 == 1) begin
        send_res(1'b0);
        check($sformatf("R9 reoffer n=%0d", n), tx_idx, n % RING);
        take1();
      end
      send_res(1'b1);
      check($sformatf("R11 rd n=%0d", n), rd_ptr, (n + 1) % RING);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule